// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Forwarding

This block gathers 32 level-sensitive interrupt sources into a single combined request for a primary interrupt controller. Each source can be masked by its own enable bit. The combined request is high while any enabled source is active.

A group of sources, bits 21 to 30, can also be forwarded one by one to dedicated primary-controller inputs. A separate forwarding enable register controls which of them are forwarded. The main mask has no effect on these lines.

Software reaches the block through a single-cycle register port. The port has a byte offset, a write strobe and write data. Read data is a combinational function of the offset and the stored state. Bit 0 also acts as a software-raised interrupt. All outputs come from registers, so a write or an input change shows on the outputs after the next rising clock edge.

Top module: `sec_irq_ctrl`

## Requirements
- R1: Word index 1 (byte offset bits [11:2]) reads the raw status. Raw status is each source level sampled at the last clock edge. Bit 0 is the OR of source 0 and the software bit.
- R2: Word index 0 reads raw status AND the enable mask. Word index 2 reads the enable mask.
- R3: A write to word index 2 sets the enable bits that are 1 in the write data. A write to word index 3 clears the enable bits that are 1 in the write data. All other enable bits keep their value.
- R4: `irq_o` is high one edge after any bit of (raw status AND enable mask) is 1, and low otherwise.
- R5: Word index 8 reads the forwarding enable. A write to index 8 sets the data bits that fall in 21..30 (mask 0x7FE00000) and ignores the rest. A write to index 9 clears the bits that are 1 in the data.
- R6: `fwd_o[k]` equals raw status bit 21+k while forwarding enable bit 21+k is set, whatever the main mask holds. It is low while that enable bit is clear.
- R7: Word index 4 reads the software bit in bit 0, and bits 31:1 read as zero. A nonzero write to index 4 sets the software bit. A nonzero write to index 5 clears it. A zero write to either index changes nothing.
- R8: Every word index other than 0, 1, 2, 4 and 8 reads as zero. A write to any index other than 2, 3, 4, 5, 8 and 9 changes no state.
- R9: A synchronous active-high `rst` clears the enable mask, the forwarding enable, the software bit and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Combined masked request to the primary controller |
| fwd_o | output | 10 | Per-source forwarded lines for sources 21..30 |

## Verification
The bench sets all bits of the forwarding enable. A design that dropped the 21..30 mask would then read back stray bits and could forward them. It forwards sources while the main mask is zero, which catches a design that gated the forwarded lines with the mask. Zero-valued writes to the software set and clear indices expose a design that tests the strobe but not the data. Writes of all ones to unmapped and read-only indices expose a decoder that aliases them onto a live register.

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int N_SRC   = 32,
  parameter int ADDR_W  = 12,
  parameter int FWD_LO  = 21,
  parameter int FWD_HI  = 30
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SRC-1:0]      src_i,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [N_SRC-1:0]      reg_wdata,
  output logic [N_SRC-1:0]      reg_rdata,
  output logic                  irq_o,
  output logic [FWD_HI-FWD_LO:0] fwd_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int FWD_N = FWD_HI - FWD_LO + 1;
  localparam logic [N_SRC-1:0] FWD_MASK = N_SRC'(((64'd1 << FWD_N) - 64'd1) << FWD_LO);
  localparam logic [IDX_W-1:0] IX_MSTAT = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_RAW   = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_ENSET = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_ENCLR = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_SWSET = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_SWCLR = IDX_W'(5);
  localparam logic [IDX_W-1:0] IX_FWSET = IDX_W'(8);
  localparam logic [IDX_W-1:0] IX_FWCLR = IDX_W'(9);

  logic [N_SRC-1:0] en_q, fw_q, raw_q;
  logic [N_SRC-1:0] en_d, fw_d, raw_d;
  logic             sw_q, sw_d;
  logic             irq_q;
  logic [FWD_N-1:0] fwd_q;

  wire [IDX_W-1:0] idx    = reg_addr[ADDR_W-1:2];
  wire             wr_any = reg_we && (reg_wdata != '0);

  assign en_d = (reg_we && idx == IX_ENSET) ? (en_q | reg_wdata)  :
                (reg_we && idx == IX_ENCLR) ? (en_q & ~reg_wdata) : en_q;
  assign fw_d = (reg_we && idx == IX_FWSET) ? (fw_q | (reg_wdata & FWD_MASK)) :
                (reg_we && idx == IX_FWCLR) ? (fw_q & ~reg_wdata) : fw_q;
  assign sw_d = (wr_any && idx == IX_SWSET) ? 1'b1 :
                (wr_any && idx == IX_SWCLR) ? 1'b0 : sw_q;
  assign raw_d = src_i | {{(N_SRC-1){1'b0}}, sw_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      fw_q  <= '0;
      sw_q  <= 1'b0;
      raw_q <= '0;
      irq_q <= 1'b0;
      fwd_q <= '0;
    end else begin
      en_q  <= en_d;
      fw_q  <= fw_d;
      sw_q  <= sw_d;
      raw_q <= raw_d;
      irq_q <= |(raw_d & en_d);
      fwd_q <= raw_d[FWD_HI:FWD_LO] & fw_d[FWD_HI:FWD_LO];
    end
  end

  always_comb begin
    case (idx)
      IX_MSTAT: reg_rdata = raw_q & en_q;
      IX_RAW:   reg_rdata = raw_q;
      IX_ENSET: reg_rdata = en_q;
      IX_SWSET: reg_rdata = {{(N_SRC-1){1'b0}}, sw_q};
      IX_FWSET: reg_rdata = fw_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_o = irq_q;
  assign fwd_o = fwd_q;

  wire wr_unmapped = reg_we && !(idx inside {IX_ENSET, IX_ENCLR, IX_SWSET,
                                             IX_SWCLR, IX_FWSET, IX_FWCLR});

  assert_sw_raw_R1: assert property (@(posedge clk) disable iff (rst)
    sw_q |-> raw_q[0]);
  assert_en_set_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(reg_we) && $past(idx) == IX_ENSET)
      |-> ((en_q & $past(reg_wdata)) == $past(reg_wdata)));
  assert_en_clr_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(reg_we) && $past(idx) == IX_ENCLR)
      |-> ((en_q & $past(reg_wdata)) == '0));
  assert_irq_match_R4: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(raw_q & en_q));
  assert_fw_range_R5: assert property (@(posedge clk) disable iff (rst)
    (fw_q & ~FWD_MASK) == '0);
  assert_fwd_off_R6: assert property (@(posedge clk) disable iff (rst)
    (fwd_o & ~fw_q[FWD_HI:FWD_LO]) == '0);
  assert_sw_set_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_any) && $past(idx) == IX_SWSET) |-> sw_q);
  assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_unmapped))
      |-> ($stable(en_q) && $stable(fw_q) && $stable(sw_q)));
  assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '0 && fw_q == '0 && !sw_q && !irq_o && fwd_o == '0));
endmodule

// File: tb/test_sec_irq_ctrl.sv
module test_sec_irq_ctrl;
  localparam int CLK_P = 20;
  localparam logic [31:0] FMASK = 32'h7FE0_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_i;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;
  logic [9:0]  fwd_o;

  sec_irq_ctrl i_sec_irq_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .fwd_o(fwd_o));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_en = 0, m_fw = 0, m_raw = 0;
  logic        m_sw = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd_model(input int ix);
    case (ix)
      0: return m_raw & m_en;
      1: return m_raw;
      2: return m_en;
      4: return {31'd0, m_sw};
      8: return m_fw;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_edge(input bit we, input int ix, input logic [31:0] d, input logic [31:0] s);
    if (we) begin
      case (ix)
        2: m_en = m_en | d;
        3: m_en = m_en & ~d;
        4: if (d != 0) m_sw = 1'b1;
        5: if (d != 0) m_sw = 1'b0;
        8: m_fw = m_fw | (d & FMASK);
        9: m_fw = m_fw & ~d;
        default: ;
      endcase
    end
    m_raw = s | {31'd0, m_sw};
  endtask

  task automatic rd(input int ix, input string req);
    reg_we = 1'b0;
    reg_addr = 12'(ix << 2);
    #1;
    chk(req, reg_rdata, rd_model(ix));
  endtask

  task automatic check_all(input string req);
    chk({req, " irq"}, {31'd0, irq_o}, {31'd0, |(m_raw & m_en)});
    chk({req, " fwd"}, {22'd0, fwd_o}, {22'd0, m_raw[30:21] & m_fw[30:21]});
    rd(0, {req, " R2 masked"});
    rd(1, {req, " R1 raw"});
    rd(2, {req, " R2 enable"});
    rd(4, {req, " R7 swbit"});
    rd(8, {req, " R5 fwen"});
  endtask

  task automatic step(input bit we, input int ix, input logic [31:0] d, input logic [31:0] s, input string req);
    reg_we = we;
    reg_addr = 12'(ix << 2);
    reg_wdata = d;
    src_i = s;
    @(posedge clk);
    model_edge(we, ix, d, s);
    @(negedge clk);
    reg_we = 1'b0;
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; src_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R9 reset");
    rst = 1'b0;

    step(1'b0, 0, 0, 32'h0000_00F0, "R1 raw sample");
    step(1'b1, 2, 32'h0000_0030, 32'h0000_00F0, "R3 R4 enable set");
    step(1'b1, 3, 32'h0000_0010, 32'h0000_00F0, "R3 enable clear");
    step(1'b1, 3, 32'hFFFF_FFFF, 32'h0000_00F0, "R4 all masked");
    step(1'b1, 8, 32'hFFFF_FFFF, 32'h7FE0_0000, "R5 fw set range");
    step(1'b0, 0, 0, 32'h2AA0_0000, "R6 fwd ignores mask");
    step(1'b1, 9, 32'h0AA0_0000, 32'h7FE0_0000, "R5 R6 fw clear");
    step(1'b1, 4, 32'h0, 32'h0, "R7 zero write set");
    step(1'b1, 4, 32'h8000_0000, 32'h0, "R7 sw set");
    step(1'b1, 2, 32'h1, 32'h0, "R1 R4 sw raises irq");
    step(1'b1, 5, 32'h0, 32'h0, "R7 zero write clear");
    step(1'b1, 6, 32'hFFFF_FFFF, 32'h0, "R8 unmapped write");
    step(1'b1, 1, 32'hFFFF_FFFF, 32'h0, "R8 readonly write");
    step(1'b1, 5, 32'h2, 32'h0, "R7 sw clear");
    for (int ix = 3; ix < 16; ix++)
      if (!(ix inside {4, 8})) rd(ix, "R8 unmapped read");

    for (int n = 0; n < 600; n++) begin
      int ix;
      logic [31:0] d, s;
      ix = int'($urandom % 12);
      d  = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      s  = $urandom;
      step(($urandom % 3) != 0, ix, d, s, "R3 R4 R6 random");
    end

    reg_we = 1'b1; reg_addr = 12'(2 << 2); reg_wdata = 32'hFFFF_FFFF;
    rst = 1'b1;
    @(posedge clk);
    m_en = 0; m_fw = 0; m_sw = 0; m_raw = 0;
    @(negedge clk);
    reg_we = 1'b0; src_i = 32'h0;
    chk("R9 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R9 fwd after reset", {22'd0, fwd_o}, 32'd0);
    rst = 1'b0;
    step(1'b0, 0, 0, 32'h0, "R9 state after reset");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule